// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block turns every bus address into one select for on-chip RAM, one for on-chip non-volatile memory, or one of several active-low external chip selects. After any reset it runs in a boot layout. Address zero then reaches the boot device, and RAM sits at a fixed high window. The boot device is the on-chip NVM or an off-chip NVM reached through chip select 0. The pin that chooses between them is sampled only while the external reset is held.

Software leaves the boot layout by writing 1 to the cancel bit of a control register. There is no way back except a reset. The block then uses the normal layout: RAM sits at zero, the on-chip NVM at a fixed window, and each external chip select decodes a programmed base and size. Chip-select map settings written during boot are staged until the cancel. Wait-state settings take effect on the next access. A watchdog reset returns to the boot layout and clears the configuration, but keeps the boot device chosen at the last external reset.

Top module: `boot_remap_dec`

## Requirements
- R1: After an external or watchdog reset, an address in window 0 (addr[31:20]==0) selects the boot device, and an address outside window 0 and window 3 raises undef_access.
- R2: While in the boot layout, an address in window 3 (0x00300000 to 0x003FFFFF) asserts ram_sel.
- R3: boot_pin is sampled on every clock edge with rst high. Value 0 selects on-chip NVM (nvm_sel) and value 1 selects off-chip NVM. After rst falls, boot_pin has no effect.
- R4: With off-chip boot in the boot layout, window 0 drives cs_n[0] low, and wait_states shows chip select 0's wait field.
- R5: A wdt_rst pulse restores the boot layout and clears all chip-select settings. It keeps the boot device chosen at the last external reset.
- R6: A write to register 0 with bit 0 = 1 leaves the boot layout. A write with bit 0 = 0 has no effect, and leaving is permanent until a reset.
- R7: In the boot layout, cs_n[N_CS-1:1] stay high.
- R8: Chip-select map fields in register i+1 take effect only after the cancel. These fields are base window bits [11:0], size code bits [13:12] (2^size windows) and enable bit 14.
- R9: The wait field of register i+1 (bits [18:16]) applies from the next access on, even in the boot layout. wait_states is the wait field of the selected chip select, and 0 when no chip select is selected.
- R10: In the normal layout, window 0 selects RAM and window 1 selects NVM. Chip select i matches when enabled and (addr[31:20]>>size)==(base>>size). Internal windows take priority over chip selects, and the lowest matching index wins. At most one select is active.
- R11: An address that matches nothing asserts no select and sets undef_access.
- R12: rd_data returns, one cycle after rd_addr, either bit 0 = 1 once the boot layout has been cancelled (0 before), or the stored fields of register i+1 with all other bits 0.
- R13: All select outputs are registered and follow bus_addr one clock later. While either reset is high, the outputs are idle: selects low, cs_n all high, undef_access and wait_states 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| boot_pin | input | 1 | Boot device choice, sampled while rst is high |
| bus_addr | input | ADDR_W | Bus address to decode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register index: 0 control, i+1 chip select i |
| wr_data | input | 32 | Register write data |
| rd_addr | input | REG_AW | Register index to read |
| rd_data | output | 32 | Registered read data |
| ram_sel | output | 1 | On-chip RAM select |
| nvm_sel | output | 1 | On-chip NVM select |
| cs_n | output | N_CS | External chip selects, active low |
| undef_access | output | 1 | Address matched no region |
| wait_states | output | WAIT_W | Wait setting of the selected chip select |

## Verification
The properties assume that rst is held for at least one edge before use, so the boot choice is defined. They also assume wdt_rst is a synchronous pulse and that the address, write and read inputs are never unknown outside reset. The stimulus drives every input on the falling clock edge from defined values. It holds rst for several cycles with a chosen boot_pin and issues watchdog pulses only between accesses. It also writes random values to the control register, so its value-0 write path is exercised along with real cancels.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic {BOOT_ONCHIP = 1'b0, BOOT_OFFCHIP = 1'b1} boot_dev_e;
  localparam int WIN_BITS     = 20;
  localparam int CFG_SIZE_LSB = 12;
  localparam int CFG_SIZE_W   = 2;
  localparam int CFG_EN_BIT   = 14;
  localparam int CFG_WAIT_LSB = 16;
  localparam int CTRL_INDEX   = 0;
endpackage

// File: rtl/brd_regs.sv
module brd_regs
  import brd_pkg::*;
#(
  parameter int N_CS     = 4,
  parameter int REGION_W = 12,
  parameter int WAIT_W   = 3,
  parameter int REG_AW   = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wdt_rst,
  input  logic                                   boot_pin,
  input  logic                                   wr_en,
  input  logic [REG_AW-1:0]                      wr_addr,
  input  logic [31:0]                            wr_data,
  input  logic [REG_AW-1:0]                      rd_addr,
  output logic                                   remapped,
  output boot_dev_e                              boot_dev,
  output logic [N_CS-1:0][REGION_W-1:0]          cs_base,
  output logic [N_CS-1:0][CFG_SIZE_W-1:0]        cs_size,
  output logic [N_CS-1:0]                        cs_en,
  output logic [N_CS-1:0][WAIT_W-1:0]            cs_wait,
  output logic [31:0]                            rd_data
);
  logic        remap_q;
  boot_dev_e   boot_q;
  logic [31:0] rd_mux;
  logic        cancel_wr;

  assign cancel_wr = wr_en && (wr_addr == REG_AW'(CTRL_INDEX)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) boot_q <= boot_dev_e'(boot_pin);
    if (rst || wdt_rst) begin
      remap_q <= 1'b1;
      cs_base <= '0;
      cs_size <= '0;
      cs_en   <= '0;
      cs_wait <= '0;
      rd_data <= '0;
    end else begin
      if (cancel_wr) remap_q <= 1'b0;
      for (int i = 0; i < N_CS; i++) begin
        if (wr_en && wr_addr == REG_AW'(i + 1)) begin
          cs_base[i] <= wr_data[REGION_W-1:0];
          cs_size[i] <= wr_data[CFG_SIZE_LSB +: CFG_SIZE_W];
          cs_en[i]   <= wr_data[CFG_EN_BIT];
          cs_wait[i] <= wr_data[CFG_WAIT_LSB +: WAIT_W];
        end
      end
      rd_data <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == REG_AW'(CTRL_INDEX)) begin
      rd_mux[0] = ~remap_q;
    end else begin
      for (int i = 0; i < N_CS; i++) begin
        if (rd_addr == REG_AW'(i + 1)) begin
          rd_mux[REGION_W-1:0]                = cs_base[i];
          rd_mux[CFG_SIZE_LSB +: CFG_SIZE_W]  = cs_size[i];
          rd_mux[CFG_EN_BIT]                  = cs_en[i];
          rd_mux[CFG_WAIT_LSB +: WAIT_W]      = cs_wait[i];
        end
      end
    end
  end

  assign remapped = remap_q;
  assign boot_dev = boot_q;

  // R6: once left, the boot layout is not re-entered without a reset
  assert_remap_oneway_R6: assert property (@(posedge clk) disable iff (rst || wdt_rst)
    !remap_q |=> !remap_q);

  // R6: a control write with bit 0 clear keeps the boot layout
  assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (rst || wdt_rst)
    (remap_q && wr_en && wr_addr == REG_AW'(CTRL_INDEX) && !wr_data[0]) |=> remap_q);

  // R5: watchdog reset returns to boot layout and keeps boot device
  assert_wdt_restore_R5: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> (remap_q && $stable(boot_q)));

  // R3: boot choice only changes while rst is high
  assert_boot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wdt_rst |=> $stable(boot_q));
endmodule

// File: rtl/brd_decode.sv
module brd_decode
  import brd_pkg::*;
#(
  parameter int N_CS             = 4,
  parameter int REGION_W         = 12,
  parameter int WAIT_W           = 3,
  parameter int RAM_REMAP_REGION = 3,
  parameter int NVM_REGION       = 1
) (
  input  logic [REGION_W-1:0]              region,
  input  logic                             remapped,
  input  boot_dev_e                        boot_dev,
  input  logic [N_CS-1:0][REGION_W-1:0]    cs_base,
  input  logic [N_CS-1:0][CFG_SIZE_W-1:0]  cs_size,
  input  logic [N_CS-1:0]                  cs_en,
  input  logic [N_CS-1:0][WAIT_W-1:0]      cs_wait,
  output logic                             ram_hit,
  output logic                             nvm_hit,
  output logic [N_CS-1:0]                  cs_hit,
  output logic                             undef,
  output logic [WAIT_W-1:0]                wait_sel
);
  logic [N_CS-1:0] cs_raw;

  for (genvar g = 0; g < N_CS; g++) begin : g_match
    assign cs_raw[g] = cs_en[g] && ((region >> cs_size[g]) == (cs_base[g] >> cs_size[g]));
  end

  always_comb begin
    ram_hit  = 1'b0;
    nvm_hit  = 1'b0;
    cs_hit   = '0;
    wait_sel = '0;
    if (remapped) begin
      if (region == '0) begin
        if (boot_dev == BOOT_OFFCHIP) begin
          cs_hit[0] = 1'b1;
          wait_sel  = cs_wait[0];
        end else begin
          nvm_hit = 1'b1;
        end
      end else if (region == REGION_W'(RAM_REMAP_REGION)) begin
        ram_hit = 1'b1;
      end
    end else begin
      if (region == '0) begin
        ram_hit = 1'b1;
      end else if (region == REGION_W'(NVM_REGION)) begin
        nvm_hit = 1'b1;
      end else begin
        for (int i = N_CS - 1; i >= 0; i--) begin
          if (cs_raw[i]) begin
            cs_hit    = '0;
            cs_hit[i] = 1'b1;
            wait_sel  = cs_wait[i];
          end
        end
      end
    end
    undef = ~(ram_hit | nvm_hit | (|cs_hit));
  end
endmodule

// File: rtl/boot_remap_dec.sv
module boot_remap_dec
  import brd_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int N_CS             = 4,
  parameter int WAIT_W           = 3,
  parameter int REG_AW           = 3,
  parameter int RAM_REMAP_REGION = 3,
  parameter int NVM_REGION       = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_rst,
  input  logic              boot_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              ram_sel,
  output logic              nvm_sel,
  output logic [N_CS-1:0]   cs_n,
  output logic              undef_access,
  output logic [WAIT_W-1:0] wait_states
);
  localparam int REGION_W = ADDR_W - WIN_BITS;

  logic                            remapped;
  boot_dev_e                       boot_dev;
  logic [N_CS-1:0][REGION_W-1:0]   cs_base;
  logic [N_CS-1:0][CFG_SIZE_W-1:0] cs_size;
  logic [N_CS-1:0]                 cs_en;
  logic [N_CS-1:0][WAIT_W-1:0]     cs_wait;
  logic [REGION_W-1:0]             region;
  logic                            ram_hit, nvm_hit, undef;
  logic [N_CS-1:0]                 cs_hit;
  logic [WAIT_W-1:0]               wait_sel;

  assign region = bus_addr[ADDR_W-1:WIN_BITS];

  brd_regs #(.N_CS(N_CS), .REGION_W(REGION_W), .WAIT_W(WAIT_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .boot_pin(boot_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .remapped(remapped), .boot_dev(boot_dev), .cs_base(cs_base), .cs_size(cs_size),
    .cs_en(cs_en), .cs_wait(cs_wait), .rd_data(rd_data)
  );

  brd_decode #(.N_CS(N_CS), .REGION_W(REGION_W), .WAIT_W(WAIT_W),
               .RAM_REMAP_REGION(RAM_REMAP_REGION), .NVM_REGION(NVM_REGION)) u_dec (
    .region(region), .remapped(remapped), .boot_dev(boot_dev), .cs_base(cs_base),
    .cs_size(cs_size), .cs_en(cs_en), .cs_wait(cs_wait), .ram_hit(ram_hit),
    .nvm_hit(nvm_hit), .cs_hit(cs_hit), .undef(undef), .wait_sel(wait_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || wdt_rst) begin
      ram_sel      <= 1'b0;
      nvm_sel      <= 1'b0;
      cs_n         <= '1;
      undef_access <= 1'b0;
      wait_states  <= '0;
    end else begin
      ram_sel      <= ram_hit;
      nvm_sel      <= nvm_hit;
      cs_n         <= ~cs_hit;
      undef_access <= undef;
      wait_states  <= wait_sel;
    end
  end

  // R10: never more than one select active
  assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, nvm_sel, ~cs_n}));

  // R11: an undefined access drives no select
  assert_undef_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    undef_access |-> (!ram_sel && !nvm_sel && (&cs_n)));

  // R4: off-chip boot answers on chip select 0 in window 0
  assert_boot_cs0_R4: assert property (@(posedge clk) disable iff (rst || wdt_rst)
    (remapped && region == '0 && boot_dev == BOOT_OFFCHIP) |=> !cs_n[0]);

  if (N_CS > 1) begin : g_gate_chk
    // R7: upper chip selects stay high in the boot layout
    assert_boot_gate_R7: assert property (@(posedge clk) disable iff (rst || wdt_rst)
      remapped |=> (&cs_n[N_CS-1:1]));
  end
endmodule

// File: tb/boot_remap_dec_test.sv
module boot_remap_dec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wdt_rst = 1'b0;
  logic        boot_pin = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ram_sel, nvm_sel, undef_access;
  logic [3:0]  cs_n;
  logic [2:0]  wait_states;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  boot_remap_dec uut (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .boot_pin(boot_pin), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ram_sel(ram_sel), .nvm_sel(nvm_sel), .cs_n(cs_n),
    .undef_access(undef_access), .wait_states(wait_states)
  );

  // behavioural reference model
  int m_remap = 1, m_boot = 0;
  int m_base[4], m_size[4], m_en[4], m_wt[4];
  int e_ram = 0, e_nvm = 0, e_csn = 15, e_undef = 0, e_wt = 0;
  logic [31:0] e_rd = '0;

  task automatic model_clear();
    m_remap = 1;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_size[i] = 0; m_en[i] = 0; m_wt[i] = 0; end
    e_ram = 0; e_nvm = 0; e_csn = 15; e_undef = 0; e_wt = 0; e_rd = '0;
  endtask

  task automatic model_decode(input logic [31:0] a);
    int reg_n;
    int hit;
    reg_n = int'(a >> 20);
    e_ram = 0; e_nvm = 0; e_csn = 15; e_wt = 0;
    if (m_remap != 0) begin
      if (reg_n == 0) begin
        if (m_boot != 0) begin e_csn = 14; e_wt = m_wt[0]; end else e_nvm = 1;
      end else if (reg_n == 3) e_ram = 1;
    end else begin
      if (reg_n == 0) e_ram = 1;
      else if (reg_n == 1) e_nvm = 1;
      else begin
        hit = -1;
        for (int i = 0; i < 4; i++)
          if (hit < 0 && m_en[i] != 0 && (reg_n >> m_size[i]) == (m_base[i] >> m_size[i])) hit = i;
        if (hit >= 0) begin e_csn = 15 & ~(1 << hit); e_wt = m_wt[hit]; end
      end
    end
    e_undef = (e_ram == 0 && e_nvm == 0 && e_csn == 15) ? 1 : 0;
  endtask

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v;
    v = '0;
    if (a == 0) v[0] = (m_remap == 0);
    else if (a <= 4) v = 32'(m_base[a-1] | (m_size[a-1] << 12) | (m_en[a-1] << 14) | (m_wt[a-1] << 16));
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_boot = boot_pin;
      model_clear();
    end else if (wdt_rst) begin
      model_clear();
    end else begin
      model_decode(bus_addr);
      e_rd = model_read(int'(rd_addr));
      if (wr_en) begin
        if (wr_addr == 0) begin
          if (wr_data[0]) m_remap = 0;
        end else if (wr_addr <= 4) begin
          m_base[wr_addr-1] = int'(wr_data[11:0]);
          m_size[wr_addr-1] = int'(wr_data[13:12]);
          m_en[wr_addr-1]   = int'(wr_data[14]);
          m_wt[wr_addr-1]   = int'(wr_data[18:16]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("R2/R10 ram_sel model", int'(ram_sel), e_ram);
      chk("R3/R10 nvm_sel model", int'(nvm_sel), e_nvm);
      chk("R4/R7/R8 cs_n model", int'(cs_n), e_csn);
      chk("R11 undef model", int'(undef_access), e_undef);
      chk("R9 wait model", int'(wait_states), e_wt);
      chk("R12 rd_data model", int'(rd_data), int'(e_rd));
    end
  end

  task automatic acc(input logic [31:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); rd_addr = 3'(a);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk); rst = 1'b1; boot_pin = pin;
    repeat (3) @(negedge clk);
    chk("R13 idle cs_n in reset", int'(cs_n), 15);
    chk("R13 idle ram_sel in reset", int'(ram_sel), 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++;
    $display("FAIL R13 watchdog actual=%0d expected<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);
    boot_pin = 1'b1;                         // R3: ignored after reset
    acc(32'h0000_0100);
    chk("R1/R3 on-chip boot at zero", int'(nvm_sel), 1);
    acc(32'h0030_0010);
    chk("R2 RAM at window 3", int'(ram_sel), 1);
    acc(32'h0010_0000);
    chk("R1/R11 window 1 undefined in boot", int'(undef_access), 1);
    wr(2, 32'h0000_5010 | (32'd5 << 16));   // cs1: base 0x010 size 1 en wait 5
    acc(32'h0100_0000);
    chk("R8/R7 staged cs1 inactive", int'(cs_n), 15);
    rd(2);
    chk("R12 cs1 readback", int'(rd_data), 32'h0005_5010);
    wr(0, 32'h0);
    acc(32'h0030_0000);
    chk("R6 zero write keeps boot layout", int'(ram_sel), 1);
    rd(0);
    chk("R12 cancel bit before cancel", int'(rd_data), 0);

    do_reset(1'b1);
    boot_pin = 1'b0;
    acc(32'h0000_0000);
    chk("R4 off-chip boot on cs0", int'(cs_n), 14);
    wr(1, 32'd3 << 16);                     // cs0 wait 3 only
    acc(32'h0000_0040);
    chk("R9 wait applies in boot layout", int'(wait_states), 3);
    wr(2, 32'h0000_5010 | (32'd5 << 16));
    wr(3, 32'h0000_4020 | (32'd2 << 16));   // cs2 base 0x020
    wr(4, 32'h0000_4010 | (32'd7 << 16));   // cs3 overlaps cs1
    acc(32'h0100_0000);
    chk("R7 upper selects high in boot", int'(cs_n), 15);
    wr(0, 32'h1);
    acc(32'h0000_0000);
    chk("R10 RAM at zero after cancel", int'(ram_sel), 1);
    acc(32'h0010_0000);
    chk("R10 NVM at window 1", int'(nvm_sel), 1);
    acc(32'h0110_0000);
    chk("R8 cs1 size-2 window", int'(cs_n), 13);
    chk("R9 cs1 wait", int'(wait_states), 5);
    acc(32'h0100_0000);
    chk("R10 lower index wins", int'(cs_n), 13);
    acc(32'h0200_0000);
    chk("R10 cs2 select", int'(cs_n), 11);
    acc(32'h0030_0000);
    chk("R11 window 3 unmatched when normal", int'(undef_access), 1);
    rd(0);
    chk("R12 cancel bit after cancel", int'(rd_data), 1);
    wr(0, 32'h0);
    acc(32'h0000_0000);
    chk("R6 no way back", int'(ram_sel), 1);

    @(negedge clk); wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    acc(32'h0000_0000);
    chk("R5 boot device kept", int'(cs_n), 14);
    wr(0, 32'h1);
    acc(32'h0100_0000);
    chk("R5 config cleared", int'(undef_access), 1);

    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      bus_addr = {8'h0, 4'($urandom_range(0, 5)), 20'($urandom)};
      bus_addr[31:20] = 12'($urandom_range(0, 40));
      rd_addr = 3'($urandom_range(0, 5));
      wr_en = ($urandom_range(0, 3) == 0);
      wr_addr = 3'($urandom_range(0, 7));
      wr_data = $urandom & 32'h0007_7FFF;
      wr_data[11:6] = 6'h0;
      if (wr_addr == 0) wr_data[0] = ($urandom_range(0, 7) == 0);
      wdt_rst = ($urandom_range(0, 150) == 0);
    end
    @(negedge clk); wr_en = 1'b0; wdt_rst = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule